// File: doc/BRIEF.md
# Block Memory Micro-Op Sequencer

This block turns one decoded block-transfer instruction, either a block load or a block store, into a fixed train of eight doubleword memory micro-operations. A request carries the transfer direction, a base register value, and either a second register value or a 13-bit signed immediate. It also carries the first floating-point register number and a flag saying whether the address-space access is legal at the current privilege.

When the request is accepted, the sequencer forms the base effective address and runs both fault checks once. If either check fails, no micro-op is issued. Instead a one-cycle fault indication with a code is produced and the block returns to idle. Otherwise the block issues the eight micro-ops in order over a valid/ready handshake. Each carries its own address, register number, direction and commit markers.

A downstream memory pipe consumes the micro-ops. The markers let it hold back architectural commit until the final element of the group has been accepted.

Top module: `blkmem_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `uop_valid` and `flt_valid` are 0.
- R2: A fault-free request yields exactly eight micro-ops, with `uop_idx` running 0 to 7 in order. After index 7 is accepted the block is idle in the next cycle.
- R3: When `req_use_imm`=0, micro-op i has address `req_rs1 + req_rs2 + 8*i` (modulo 2^64).
- R4: When `req_use_imm`=1, micro-op i has address `req_rs1 + sext(req_imm) + 8*i`. The 13-bit immediate is sign-extended from bit 12.
- R5: Micro-op 0 has `uop_first`=1. Micro-ops 0 to 6 have `uop_dcommit`=1 and `uop_last`=0. Micro-op 7 has `uop_last`=1 and `uop_dcommit`=0. `uop_first` is 0 for indices 1 to 7.
- R6: Micro-op i carries register number `req_freg + 2*i`, modulo 64.
- R7: If bits [5:0] of the base effective address are not all zero, the request faults with `flt_code`=2'b10 (alignment).
- R8: If the address is aligned and `req_asi_ok`=0, the request faults with `flt_code`=2'b01 (privilege).
- R9: If both faults apply, the code reported is 2'b10; alignment wins.
- R10: A faulting request issues no micro-op. `flt_valid` is 1 for exactly the cycle after acceptance, and the block is idle in the cycle after that.
- R11: While `uop_valid`=1 and `uop_ready`=0, every micro-op output holds its value into the next cycle.
- R12: While a sequence or fault is in progress, `req_ready` is 0 and a `req_valid` pulse does not alter the running sequence.
- R13: Every micro-op of a sequence carries the `req_store` value of its request on `uop_store`. Load and store sequences are otherwise identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_store | input | 1 | 1 = block store, 0 = block load |
| req_use_imm | input | 1 | 1 = immediate operand, 0 = second register |
| req_rs1 | input | 64 | Base register value |
| req_rs2 | input | 64 | Second register value |
| req_imm | input | 13 | Signed immediate |
| req_freg | input | 6 | First floating-point register number |
| req_asi_ok | input | 1 | Address space legal at current privilege |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Micro-op taken |
| uop_addr | output | 64 | Micro-op effective address |
| uop_freg | output | 6 | Micro-op register number |
| uop_idx | output | 3 | Position in the group |
| uop_store | output | 1 | Direction of this micro-op |
| uop_first | output | 1 | First of group |
| uop_last | output | 1 | Last of group |
| uop_dcommit | output | 1 | Commit deferred |
| flt_valid | output | 1 | Fault indication, one cycle |
| flt_code | output | 2 | 2'b10 alignment, 2'b01 privilege |

## Verification
A corrupted position counter would show up at once on `uop_idx`, `uop_addr` and `uop_freg` in the cycle of the wrong step. It would also make the group too short or too long, which is visible at `req_ready` when the block should be idle. A wrong latched fault decision shows in the cycle after acceptance, as either a spurious micro-op or a missing `flt_valid`. A lost context register shows on the first micro-op's address, register number or direction. Since every port is compared on every clock against a behavioural model, each of these is caught in the first cycle it appears.

// File: rtl/blkmem_pkg.sv
`timescale 1ns/1ps
package blkmem_pkg;

    localparam int unsigned ADDR_W = 64;
    localparam int unsigned IMM_W  = 13;
    localparam int unsigned FREG_W = 6;
    localparam int unsigned CODE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_e;

    // Fault codes as seen on flt_code
    localparam logic [CODE_W-1:0] FLT_NONE  = 2'b00;
    localparam logic [CODE_W-1:0] FLT_PRIV  = 2'b01;
    localparam logic [CODE_W-1:0] FLT_ALIGN = 2'b10;

    // Per-group context captured on acceptance
    typedef struct packed {
        logic              store;
        logic [ADDR_W-1:0] base;
        logic [FREG_W-1:0] freg;
    } grp_ctx_t;

    function automatic logic [ADDR_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(ADDR_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/blkmem_ea.sv
`timescale 1ns/1ps
module blkmem_ea
    import blkmem_pkg::*;
(
    input  logic              use_imm,
    input  logic [ADDR_W-1:0] rs1,
    input  logic [ADDR_W-1:0] rs2,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] ea
);
    logic [ADDR_W-1:0] operand_b;

    always_comb begin
        operand_b = use_imm ? sext_imm(imm) : rs2;
        ea        = rs1 + operand_b;
    end
endmodule

// File: rtl/blkmem_fault.sv
`timescale 1ns/1ps
module blkmem_fault
    import blkmem_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = 6
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic              asi_ok,
    output logic              fault,
    output logic [CODE_W-1:0] code
);
    logic misaligned;

    always_comb begin
        misaligned = |ea[ALIGN_BITS-1:0];
        // Lower priority first; alignment overrides it
        code = FLT_NONE;
        if (!asi_ok)   code = FLT_PRIV;
        if (misaligned) code = FLT_ALIGN;
        fault = misaligned || !asi_ok;
    end
endmodule

// File: rtl/blkmem_agen.sv
`timescale 1ns/1ps
module blkmem_agen
    import blkmem_pkg::*;
#(
    parameter int unsigned IDX_W      = 3,
    parameter int unsigned STEP_BYTES = 8,
    parameter int unsigned FREG_STEP  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [FREG_W-1:0] freg_base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic [FREG_W-1:0] freg
);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP_BYTES);
    localparam logic [FREG_W-1:0] STEP_F = FREG_W'(FREG_STEP);

    always_comb begin
        addr = base + ADDR_W'(idx) * STEP_A;
        freg = freg_base + FREG_W'(idx) * STEP_F;
    end
endmodule

// File: rtl/blkmem_ctrl.sv
`timescale 1ns/1ps
module blkmem_ctrl
    import blkmem_pkg::*;
#(
    parameter int unsigned NUM_UOPS = 8,
    parameter int unsigned IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_fault,
    input  logic [CODE_W-1:0] req_code,
    input  grp_ctx_t          req_ctx,
    output logic              req_ready,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [IDX_W-1:0]  idx,
    output grp_ctx_t          ctx,
    output logic              flt_valid,
    output logic [CODE_W-1:0] flt_code
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UOPS - 1);

    seq_state_e        state_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx     <= '0;
            code_q  <= FLT_NONE;
            ctx     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctx    <= req_ctx;
                        idx    <= '0;
                        code_q <= req_code;
                        state_q <= req_fault ? ST_FAULT : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (uop_ready) begin
                        if (idx == LAST_IDX) begin
                            state_q <= ST_IDLE;
                            idx     <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_FAULT: begin
                    state_q <= ST_IDLE;
                    code_q  <= FLT_NONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        uop_valid = (state_q == ST_ISSUE);
        flt_valid = (state_q == ST_FAULT);
        flt_code  = flt_valid ? code_q : FLT_NONE;
    end
endmodule

// File: rtl/blkmem_seq.sv
`timescale 1ns/1ps
module blkmem_seq
    import blkmem_pkg::*;
#(
    parameter int unsigned NUM_UOPS   = 8,
    parameter int unsigned STEP_BYTES = 8,
    parameter int unsigned FREG_STEP  = 2,
    parameter int unsigned ALIGN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic              req_use_imm,
    input  logic [63:0]       req_rs1,
    input  logic [63:0]       req_rs2,
    input  logic [12:0]       req_imm,
    input  logic [5:0]        req_freg,
    input  logic              req_asi_ok,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [63:0]       uop_addr,
    output logic [5:0]        uop_freg,
    output logic [2:0]        uop_idx,
    output logic              uop_store,
    output logic              uop_first,
    output logic              uop_last,
    output logic              uop_dcommit,
    output logic              flt_valid,
    output logic [1:0]        flt_code
);
    localparam int unsigned IDX_W = $clog2(NUM_UOPS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UOPS - 1);

    logic [ADDR_W-1:0] req_ea;
    logic              req_fault;
    logic [CODE_W-1:0] req_code;
    grp_ctx_t          req_ctx;
    grp_ctx_t          ctx;
    logic [IDX_W-1:0]  idx;

    blkmem_ea u_ea (
        .use_imm (req_use_imm),
        .rs1     (req_rs1),
        .rs2     (req_rs2),
        .imm     (req_imm),
        .ea      (req_ea)
    );

    blkmem_fault #(.ALIGN_BITS(ALIGN_BITS)) u_fault (
        .ea     (req_ea),
        .asi_ok (req_asi_ok),
        .fault  (req_fault),
        .code   (req_code)
    );

    always_comb begin
        req_ctx.store = req_store;
        req_ctx.base  = req_ea;
        req_ctx.freg  = req_freg;
    end

    blkmem_ctrl #(.NUM_UOPS(NUM_UOPS), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_fault (req_fault),
        .req_code  (req_code),
        .req_ctx   (req_ctx),
        .req_ready (req_ready),
        .uop_valid (uop_valid),
        .uop_ready (uop_ready),
        .idx       (idx),
        .ctx       (ctx),
        .flt_valid (flt_valid),
        .flt_code  (flt_code)
    );

    blkmem_agen #(
        .IDX_W      (IDX_W),
        .STEP_BYTES (STEP_BYTES),
        .FREG_STEP  (FREG_STEP)
    ) u_agen (
        .base      (ctx.base),
        .freg_base (ctx.freg),
        .idx       (idx),
        .addr      (uop_addr),
        .freg      (uop_freg)
    );

    always_comb begin
        uop_idx     = 3'(idx);
        uop_store   = ctx.store;
        uop_first   = (idx == '0);
        uop_last    = (idx == LAST_IDX);
        uop_dcommit = !uop_last;
    end
endmodule

// File: rtl/blkmem_seq_chk.sv
`timescale 1ns/1ps
module blkmem_seq_chk #(
    parameter int unsigned STEP_BYTES = 8,
    parameter int unsigned FREG_STEP  = 2,
    parameter int unsigned ALIGN_BITS = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        uop_valid,
    input logic        uop_ready,
    input logic [63:0] uop_addr,
    input logic [5:0]  uop_freg,
    input logic [2:0]  uop_idx,
    input logic        uop_store,
    input logic        uop_first,
    input logic        uop_last,
    input logic        flt_valid
);
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_addr) && $stable(uop_freg)
                                       && $stable(uop_idx) && $stable(uop_store))); // R11
    AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && !uop_last) |=>
            (uop_valid && uop_addr == $past(uop_addr) + 64'(STEP_BYTES))); // R3
    AST_FREG_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && !uop_last) |=>
            (uop_freg == 6'($past(uop_freg) + 6'(FREG_STEP)))); // R6
    AST_DIR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && !uop_last) |=> $stable(uop_store)); // R13
    AST_GROUP_END: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && uop_last) |=> (req_ready && !uop_valid)); // R2
    AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_first) |-> (uop_addr[ALIGN_BITS-1:0] == '0)); // R7
    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> (!flt_valid && !uop_valid && req_ready)); // R10
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flt_valid && uop_valid)); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (uop_valid || flt_valid) |-> !req_ready); // R12
endmodule

bind blkmem_seq blkmem_seq_chk #(
    .STEP_BYTES (STEP_BYTES),
    .FREG_STEP  (FREG_STEP),
    .ALIGN_BITS (ALIGN_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .uop_valid (uop_valid),
    .uop_ready (uop_ready),
    .uop_addr  (uop_addr),
    .uop_freg  (uop_freg),
    .uop_idx   (uop_idx),
    .uop_store (uop_store),
    .uop_first (uop_first),
    .uop_last  (uop_last),
    .flt_valid (flt_valid)
);

// File: tb/blkmem_seq_bench.sv
`timescale 1ns/1ps
module blkmem_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic        req_use_imm = 1'b0;
    logic [63:0] req_rs1 = '0;
    logic [63:0] req_rs2 = '0;
    logic [12:0] req_imm = '0;
    logic [5:0]  req_freg = '0;
    logic        req_asi_ok = 1'b1;
    logic        uop_valid;
    logic        uop_ready = 1'b1;
    logic [63:0] uop_addr;
    logic [5:0]  uop_freg;
    logic [2:0]  uop_idx;
    logic        uop_store, uop_first, uop_last, uop_dcommit;
    logic        flt_valid;
    logic [1:0]  flt_code;

    blkmem_seq u_blkmem_seq (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit stall_mode = 0;
    bit done = 0;

    // Behavioural reference: 0 idle, 1 issuing, 2 fault
    int          m_state = 0;
    int          m_idx = 0;
    logic [63:0] m_base = '0;
    int          m_freg = 0;
    logic        m_store = 0;
    logic [1:0]  m_code = 0;
    string       m_atag = "R3";
    string       m_ftag = "R7";

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_state = 0; m_idx = 0;
        end else begin
            case (m_state)
                0: if (req_valid) begin
                    m_base  = req_rs1 + (req_use_imm ? {{51{req_imm[12]}}, req_imm} : req_rs2);
                    m_freg  = req_freg;
                    m_store = req_store;
                    m_idx   = 0;
                    m_atag  = req_use_imm ? "R4" : "R3";
                    if (m_base[5:0] != 0) begin
                        m_code = 2'b10; m_state = 2;
                        m_ftag = req_asi_ok ? "R7" : "R9";
                    end else if (!req_asi_ok) begin
                        m_code = 2'b01; m_state = 2; m_ftag = "R8";
                    end else m_state = 1;
                end
                1: if (uop_ready) begin
                    if (m_idx == 7) m_state = 0; else m_idx++;
                end
                default: m_state = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(req_ready == (m_state == 0), (m_state == 0) ? "R1" : "R12", 64'(req_ready), 64'(m_state == 0));
            chk(uop_valid == (m_state == 1), (m_state == 2) ? "R10" : "R2", 64'(uop_valid), 64'(m_state == 1));
            chk(flt_valid == (m_state == 2), "R10", 64'(flt_valid), 64'(m_state == 2));
            if (m_state == 1) begin
                chk(uop_idx == 3'(m_idx), "R2", 64'(uop_idx), 64'(m_idx));
                chk(uop_addr == m_base + 64'(m_idx * 8), m_atag, uop_addr, m_base + 64'(m_idx * 8));
                chk(uop_freg == 6'(m_freg + 2 * m_idx), "R6", 64'(uop_freg), 64'(6'(m_freg + 2 * m_idx)));
                chk(uop_store == m_store, "R13", 64'(uop_store), 64'(m_store));
                chk(uop_first == (m_idx == 0), "R5", 64'(uop_first), 64'(m_idx == 0));
                chk(uop_last == (m_idx == 7), "R5", 64'(uop_last), 64'(m_idx == 7));
                chk(uop_dcommit == (m_idx != 7), "R5", 64'(uop_dcommit), 64'(m_idx != 7));
            end
            if (m_state == 2)
                chk(flt_code == m_code, m_ftag, 64'(flt_code), 64'(m_code));
        end
        // ready pattern for next edge; R11 stalls when stall_mode
        uop_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    task automatic wait_idle();
        do @(negedge clk); while (m_state != 0);
    endtask

    task automatic send(input bit st, input bit ui, input logic [63:0] a, input logic [63:0] b,
                        input logic [12:0] im, input logic [5:0] fr, input bit ok, input bit poke);
        wait_idle();
        req_valid = 1; req_store = st; req_use_imm = ui;
        req_rs1 = a; req_rs2 = b; req_imm = im; req_freg = fr; req_asi_ok = ok;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            // R12: foreign request offered while busy must be ignored
            req_valid = 1; req_store = ~st; req_rs1 = 64'h55; req_freg = 6'd3; req_asi_ok = 0;
            repeat (4) @(negedge clk);
            req_valid = 0;
        end
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        send(1, 0, 64'h1000, 64'h40, '0, 6'd0, 1, 0);               // R3 R13 store
        stall_mode = 1;
        send(0, 1, 64'h2040, 64'h0, 13'h1FC0, 6'd56, 1, 1);          // R4 R6 wrap, R11, R12
        send(1, 1, 64'hFFFF_FFFF_FFFF_FFC0, 64'h0, 13'h0FC0, 6'd10, 1, 0); // R4 carry
        stall_mode = 0;
        send(0, 0, 64'h3004, 64'h0, '0, 6'd0, 1, 0);                 // R7
        send(0, 0, 64'h3000, 64'h40, '0, 6'd0, 0, 0);                // R8
        send(1, 1, 64'h3000, 64'h0, 13'h0008, 6'd0, 0, 0);           // R9
        send(0, 0, 64'h7FC0, 64'h0, '0, 6'd62, 1, 1);                // R2 R5 load
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule